// File: doc/BRIEF.md
# Desaturation Guard with Soft Turn-Off

This block protects one power-switch gate-drive channel against desaturation. It takes the channel's on/off command, a freeze request from the fault manager and the digitized output of the collector-voltage comparator. It produces three driver enables: the normal pull-up, the normal pull-down and a weak soft-turn-off pull-down. It also produces two status signals for the fault manager: a flag that stays high while a soft turn-off runs, and a one-cycle pulse when that turn-off finishes.

The comparator output passes through a two-flop synchronizer. Sensing is enabled only while the channel is driven on and the blanking window that follows each turn-on has expired. A trip requires an unbroken run of high samples. When a trip is accepted, both normal drivers are released and the soft pull-down alone discharges the gate for a fixed time. The channel then stays off until its command is taken low. All durations are parameters in clock cycles. Their defaults are derived from `CLK_MHZ`: 3 µs of blanking, 1 µs of filtering and 9.6 µs of soft turn-off.

Top module: `desat_guard`

## Requirements
- R1: While reset is active, and right after it, `pd_en` is 1 and `pu_en`, `ssd_en`, `desat_active` and `ssd_done` are 0.
- R2: In normal operation with `hold` low, `pu_en` takes the value of `cmd_on` one clock later and `pd_en` is its complement. At most one of `pu_en`, `pd_en` and `ssd_en` is 1 at any time.
- R3: For `BLANK_CYC` cycles after each off-to-on transition of the driven output, the comparator input is ignored. No trip can occur before the output has been on for at least that long.
- R4: While the driven output is off, a high comparator input has no effect: no trip occurs and `pd_en` stays 1.
- R5: A trip needs `FILT_CYC` consecutive high synchronized samples taken while sensing is enabled, and a single low sample restarts the count. When sensing is already enabled, `desat_active` rises `FILT_CYC+2` cycles after the input goes high.
- R6: During a soft turn-off, `pu_en` and `pd_en` are 0 and `ssd_en` is 1. Changes of `cmd_on` or `hold` have no effect during this time.
- R7: `desat_active` stays high for exactly `SSD_CYC` cycles. After that the channel is held off with `pd_en` at 1.
- R8: `ssd_done` is a single-cycle pulse. It is high in the first cycle after `desat_active` falls.
- R9: After a soft turn-off, the channel stays off while `cmd_on` remains 1. Once `cmd_on` has been low, a later high command turns the output on again.
- R10: While `hold` is 1, the driven output keeps its state whatever `cmd_on` does. Desaturation sensing still runs and can trip the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_on | input | 1 | Channel on/off command |
| hold | input | 1 | Freeze request: keep the present output state |
| desat_in | input | 1 | Raw comparator output, high means desaturation |
| pu_en | output | 1 | Normal pull-up driver enable |
| pd_en | output | 1 | Normal pull-down driver enable |
| ssd_en | output | 1 | Soft turn-off pull-down enable |
| desat_active | output | 1 | High for the whole soft turn-off |
| ssd_done | output | 1 | One-cycle pulse when the soft turn-off ends |

## Verification
A filter count that is kept instead of cleared by a low sample would let short pulses add up to a trip. That fault shows as `desat_active` rising within a few cycles of the second short pulse. A blanking or soft-turn-off counter with a wrong load value moves the rise or fall of `desat_active` by a fixed number of cycles, so the bench measures both edges exactly. A drive-state register that is released too early shows as `pu_en` rising while `cmd_on` is still high after a trip. A state that misses the freeze shows as `pu_en` falling in the cycle after `cmd_on` drops.

// File: rtl/desat_guard.sv
module desat_guard #(
  parameter int CLK_MHZ   = 50,
  parameter int BLANK_CYC = 3 * CLK_MHZ,
  parameter int FILT_CYC  = CLK_MHZ,
  parameter int SSD_CYC   = (96 * CLK_MHZ) / 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_on,
  input  logic hold,
  input  logic desat_in,
  output logic pu_en,
  output logic pd_en,
  output logic ssd_en,
  output logic desat_active,
  output logic ssd_done
);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int FW = $clog2(FILT_CYC + 1);
  localparam int SW = $clog2(SSD_CYC + 1);

  typedef enum logic [1:0] {ST_RUN, ST_SSD, ST_LOCK} st_t;

  st_t           st;
  logic          out_on, s1, s2;
  logic [BW-1:0] blank_cnt;
  logic [FW-1:0] filt_cnt;
  logic [SW-1:0] ssd_cnt;

  wire running = (st == ST_RUN);
  wire sensing = running && out_on && (blank_cnt == BW'(0));
  wire trip    = sensing && s2 && (filt_cnt == FW'(FILT_CYC - 1));
  wire turn_on = running && !hold && cmd_on && !out_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= desat_in;
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  blank_cnt <= '0;
    else if (turn_on)            blank_cnt <= BW'(BLANK_CYC);
    else if (blank_cnt != BW'(0)) blank_cnt <= blank_cnt - BW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  filt_cnt <= '0;
    else if (sensing && s2 && !trip) filt_cnt <= filt_cnt + FW'(1);
    else                         filt_cnt <= '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= ST_RUN;
      out_on   <= 1'b0;
      ssd_cnt  <= '0;
      ssd_done <= 1'b0;
    end else begin
      ssd_done <= 1'b0;
      case (st)
        ST_RUN:
          if (trip) begin
            st      <= ST_SSD;
            out_on  <= 1'b0;
            ssd_cnt <= SW'(SSD_CYC - 1);
          end else if (!hold) out_on <= cmd_on;
        ST_SSD:
          if (ssd_cnt == SW'(0)) begin
            st       <= ST_LOCK;
            ssd_done <= 1'b1;
          end else ssd_cnt <= ssd_cnt - SW'(1);
        default:
          if (!cmd_on) st <= ST_RUN;
      endcase
    end

  assign pu_en        = running && out_on;
  assign pd_en        = (running && !out_on) || (st == ST_LOCK);
  assign ssd_en       = (st == ST_SSD);
  assign desat_active = ssd_en;
endmodule

// File: rtl/desat_guard_chk.sv
module desat_guard_chk #(
  parameter int BLANK_CYC = 4,
  parameter int SSD_CYC   = 4
) (
  input logic clk,
  input logic rst_n,
  input logic pu_en,
  input logic pd_en,
  input logic ssd_en,
  input logic desat_active,
  input logic ssd_done
);
  int on_cnt, act_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      on_cnt  <= 0;
      act_cnt <= 0;
    end else begin
      on_cnt  <= !pu_en ? 0 : (on_cnt < BLANK_CYC ? on_cnt + 1 : on_cnt);
      act_cnt <= desat_active ? act_cnt + 1 : 0;
    end

  // R2
  drv_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pu_en, pd_en, ssd_en}));

  // R4
  trip_from_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desat_active) |-> $past(pu_en));

  // R3
  blank_respected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(desat_active) |-> $past(on_cnt) >= BLANK_CYC);

  // R7
  ssd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_cnt <= SSD_CYC);

  // R7
  lock_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ssd_done |-> pd_en && !pu_en);

  // R8
  done_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(desat_active) |-> ssd_done);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ssd_done |=> !ssd_done);
endmodule

bind desat_guard desat_guard_chk #(.BLANK_CYC(BLANK_CYC), .SSD_CYC(SSD_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .pu_en(pu_en), .pd_en(pd_en), .ssd_en(ssd_en),
  .desat_active(desat_active), .ssd_done(ssd_done));

// File: tb/desat_guard_test.sv
module desat_guard_test;
  localparam int CLK_PER = 10;
  localparam int BL = 20;
  localparam int FL = 6;
  localparam int SS = 40;

  logic clk = 1'b0, rst_n = 1'b0, cmd_on = 1'b0, hold = 1'b0, desat_in = 1'b0;
  logic pu_en, pd_en, ssd_en, desat_active, ssd_done;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #(CLK_PER / 2) clk = ~clk;

  desat_guard #(.BLANK_CYC(BL), .FILT_CYC(FL), .SSD_CYC(SS)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .hold(hold), .desat_in(desat_in),
    .pu_en(pu_en), .pd_en(pd_en), .ssd_en(ssd_en),
    .desat_active(desat_active), .ssd_done(ssd_done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_idle;
    desat_in = 1'b0; hold = 1'b0; cmd_on = 1'b0;
    cyc(SS + 5);
  endtask

  task automatic t_reset;
    chk(pd_en && !pu_en && !ssd_en && !desat_active && !ssd_done, "R1 reset outputs",
        {pu_en, pd_en, ssd_en, desat_active, ssd_done}, 5'b01000);
  endtask

  task automatic t_follow;
    cmd_on = 1'b1; cyc(1);
    chk(pu_en && !pd_en, "R2 turn on", {pu_en, pd_en}, 2'b10);
    cmd_on = 1'b0; cyc(1);
    chk(!pu_en && pd_en, "R2 turn off", {pu_en, pd_en}, 2'b01);
  endtask

  task automatic t_off_ignored;
    int trips = 0, pd_low = 0;
    cmd_on = 1'b0; desat_in = 1'b1;
    for (int i = 0; i < 60; i++) begin
      cyc(1);
      if (desat_active) trips++;
      if (!pd_en) pd_low++;
    end
    chk(trips == 0, "R4 no trip while off", trips, 0);
    chk(pd_low == 0, "R4 pull-down held", pd_low, 0);
    desat_in = 1'b0; cyc(3);
  endtask

  task automatic t_blank_short;
    int trips = 0;
    cmd_on = 1'b1; desat_in = 1'b1;
    cyc(BL - 3);
    desat_in = 1'b0;
    for (int i = 0; i < 40; i++) begin
      cyc(1);
      if (desat_active) trips++;
    end
    chk(trips == 0, "R3 high only inside blanking", trips, 0);
    go_idle();
  endtask

  task automatic t_blank_late;
    int n = 0;
    cmd_on = 1'b1; desat_in = 1'b1;
    while (!desat_active && n < 200) begin cyc(1); n++; end
    chk(n == BL + FL + 1, "R3 trip after blanking", n, BL + FL + 1);
    go_idle();
  endtask

  task automatic t_filter;
    int trips = 0;
    int n = 0;
    cmd_on = 1'b1; cyc(BL + 5);
    desat_in = 1'b1; cyc(FL - 1); desat_in = 1'b0; cyc(1);
    desat_in = 1'b1; cyc(FL - 1); desat_in = 1'b0;
    for (int i = 0; i < 20; i++) begin
      cyc(1);
      if (desat_active) trips++;
    end
    chk(trips == 0, "R5 short pulses rejected", trips, 0);
    desat_in = 1'b1; cyc(FL); desat_in = 1'b0;
    while (!desat_active && n < 20) begin cyc(1); n++; end
    chk(desat_active, "R5 minimum pulse accepted", desat_active, 1);
    go_idle();
  endtask

  task automatic t_trip;
    int n = 0, len = 1, mid_bad = 0;
    cmd_on = 1'b1; cyc(BL + 5);
    desat_in = 1'b1;
    while (!desat_active && n < 50) begin cyc(1); n++; end
    chk(n == FL + 2, "R5 trip latency", n, FL + 2);
    chk(!pu_en && !pd_en && ssd_en, "R6 soft turn-off drivers",
        {pu_en, pd_en, ssd_en}, 3'b001);
    desat_in = 1'b0;
    cmd_on = 1'b0; hold = 1'b1;
    cyc(1);
    while (desat_active && len < 200) begin
      if (pu_en || pd_en || !ssd_en) mid_bad++;
      if (len == SS / 2) begin cmd_on = 1'b1; hold = 1'b0; end
      cyc(1); len++;
    end
    chk(mid_bad == 0, "R6 commands ignored", mid_bad, 0);
    chk(len == SS, "R7 soft turn-off length", len, SS);
    chk(ssd_done, "R8 done pulse high", ssd_done, 1);
    cyc(1);
    chk(!ssd_done, "R8 done pulse single", ssd_done, 0);
    chk(pd_en && !pu_en, "R7 held off after", {pu_en, pd_en}, 2'b01);
    cyc(10);
    chk(!pu_en && pd_en, "R9 stays off with command high", {pu_en, pd_en}, 2'b01);
    cmd_on = 1'b0; cyc(2);
    cmd_on = 1'b1; cyc(2);
    chk(pu_en, "R9 resumes after low command", pu_en, 1);
    go_idle();
  endtask

  task automatic t_hold;
    int n = 0;
    cmd_on = 1'b1; cyc(BL + 5);
    hold = 1'b1; cmd_on = 1'b0; cyc(5);
    chk(pu_en, "R10 frozen on", pu_en, 1);
    desat_in = 1'b1;
    while (!desat_active && n < 50) begin cyc(1); n++; end
    chk(desat_active, "R10 trip while frozen", desat_active, 1);
    go_idle();
    hold = 1'b1; cmd_on = 1'b1; cyc(5);
    chk(!pu_en, "R10 frozen off", pu_en, 0);
    hold = 1'b0; cyc(1);
    chk(pu_en, "R10 release follows command", pu_en, 1);
    go_idle();
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1; cyc(2);
    t_reset();
    t_follow();
    t_off_ignored();
    t_blank_short();
    t_blank_late();
    t_filter();
    t_trip();
    t_hold();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule